// File: doc/BRIEF.md
# Ping-Pong Block DMA Channel

This block is one DMA channel between system memory and a peripheral on a 16-bit I/O bus. Each direction has two address registers. The current pointer addresses the block being moved, and the queued pointer names the block that comes after it. Memory traffic runs in bursts of a fixed number of 32-bit words. Each burst is held in a small staging store. On the peripheral side the staging store is emptied or filled one 16-bit half at a time, low half first.

After each burst the current pointer moves forward by the burst size. When it reaches a block boundary there are two cases. If software has loaded a fresh queued pointer, the channel jumps to it without pausing and raises a sticky update flag. If it has not, the channel raises a sticky overrun flag and switches that direction off. Software keeps a transfer running by reloading the queued pointer once in every block period. When both directions are enabled, they take turns burst by burst.

Top module: `dbl_dma_channel`

## Requirements
- R1: After reset all registers read zero, `irq` is low and `mem_req` is low.
- R2: A transmit burst reads `BURST_WORDS` words starting at the transmit current pointer (`mem_we`=0). It then offers them on `dev_tx_data`, bits [15:0] of each word before bits [31:16], in word order.
- R3: A receive burst collects 2·`BURST_WORDS` halves from the device, the first half of each pair into bits [15:0]. It then writes the words at the receive current pointer (`mem_we`=1), one per cycle with `mem_wvalid`.
- R4: After a burst that does not end a block, the current pointer of that direction grows by 4·`BURST_WORDS`.
- R5: A burst that ends a block (the advanced address has its low `BLK_LOG2` bits zero) with the queued pointer valid has three effects. The current pointer is loaded from the queued one, the valid flag clears, and the update flag sets. The transfer then goes on without software action.
- R6: A burst that ends a block with no valid queued pointer also has three effects. The overrun flag sets, the direction's enable bit clears, and the current pointer keeps its value. No further memory request is made for that direction.
- R7: Writing a queued pointer register sets that direction's valid flag: status bit 8 for transmit, bit 9 for receive.
- R8: Status bits 0 (tx update), 1 (rx update), 2 (tx overrun) and 3 (rx overrun) clear when 1 is written to them. Writing 0 leaves them as they are.
- R9: `irq` is the OR of status bits [3:0] ANDed with control bits [7:4], taken bit by bit.
- R10: Clearing an enable bit lets the burst in progress complete. The direction then idles, and both of its pointers keep their values.
- R11: With both enable bits set, successive memory grants alternate between transmit and receive.
- R12: `mem_req` stays high with a stable address and direction until `mem_gnt`. `dev_tx_data` stays stable while `dev_tx_valid` is high and `dev_tx_ready` is low.

Register map (`reg_addr`): 0 control: bit 0 tx enable, bit 1 rx enable, bits [7:4] interrupt enables. 1 status. 2 tx current. 3 tx queued. 4 rx current. 5 rx queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Masked interrupt |
| mem_req | output | 1 | Burst request |
| mem_we | output | 1 | 1 = burst writes memory |
| mem_addr | output | ADDR_W | Burst byte address |
| mem_len | output | 3 | Burst length in words |
| mem_gnt | input | 1 | Burst grant |
| mem_rdata | input | 32 | Read word |
| mem_rvalid | input | 1 | Read word valid |
| mem_wdata | output | 32 | Write word |
| mem_wvalid | output | 1 | Write word valid |
| dev_tx_data | output | 16 | Half-word to device |
| dev_tx_valid | output | 1 | Half-word to device valid |
| dev_tx_ready | input | 1 | Device accepts half-word |
| dev_rx_data | input | 16 | Half-word from device |
| dev_rx_valid | input | 1 | Half-word from device valid |
| dev_rx_ready | output | 1 | Channel accepts half-word |

## Verification
The bench builds the channel with four-word bursts and `BLK_LOG2`=5, which gives 32-byte blocks. A block boundary therefore falls every second burst, so handover, reload and overrun all occur within a few hundred cycles. With full-length bursts, the half-word ordering is exercised across every staging slot. With short blocks, alternating transmit and receive bursts can be watched across several handovers in one run.

// File: rtl/dmachan_pkg.sv
package dmachan_pkg;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } dir_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_REQ,
        ST_MRD,
        ST_MWR,
        ST_DRAIN,
        ST_DONE
    } eng_st_e;

    localparam logic [2:0] RA_CTRL  = 3'd0;
    localparam logic [2:0] RA_STAT  = 3'd1;
    localparam logic [2:0] RA_TXCUR = 3'd2;
    localparam logic [2:0] RA_TXNXT = 3'd3;
    localparam logic [2:0] RA_RXCUR = 3'd4;
    localparam logic [2:0] RA_RXNXT = 3'd5;

    // ie order matches status[3:0]: tx upd, rx upd, tx ovr, rx ovr
    typedef struct packed {
        logic [3:0] ie;
        logic [1:0] en;
    } ctrl_t;

    function automatic logic [15:0] half_of(input logic [31:0] w, input logic hi);
        return hi ? w[31:16] : w[15:0];
    endfunction

endpackage

// File: rtl/dmachan_ptr_pair.sv
module dmachan_ptr_pair #(
    parameter int AW          = 32,
    parameter int BURST_BYTES = 16,
    parameter int BLK_LOG2    = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_cur,
    input  logic          wr_next,
    input  logic [AW-1:0] wdata,
    input  logic          clr_upd,
    input  logic          clr_ovr,
    input  logic          adv,
    output logic [AW-1:0] cur,
    output logic [AW-1:0] nxt,
    output logic          nvalid,
    output logic          upd,
    output logic          ovr,
    output logic          stop_o
);

    logic [AW-1:0] cur_inc;
    logic          blk_end;

    assign cur_inc = cur + AW'(BURST_BYTES);
    assign blk_end = (cur_inc[BLK_LOG2-1:0] == '0);
    assign stop_o  = adv && blk_end && !nvalid;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur    <= '0;
            nxt    <= '0;
            nvalid <= 1'b0;
            upd    <= 1'b0;
            ovr    <= 1'b0;
        end else begin
            if (clr_upd) upd <= 1'b0;
            if (clr_ovr) ovr <= 1'b0;
            if (adv) begin
                if (!blk_end) begin
                    cur <= cur_inc;
                end else if (nvalid) begin
                    cur    <= nxt;
                    nvalid <= 1'b0;
                    upd    <= 1'b1;
                end else begin
                    ovr <= 1'b1;
                end
            end
            if (wr_cur) cur <= wdata;
            if (wr_next) begin
                nxt    <= wdata;
                nvalid <= 1'b1;
            end
        end
    end

    a_r4_step: assert property (@(posedge clk) disable iff (rst)
        adv && !blk_end && !wr_cur |=> cur == $past(cur) + AW'(BURST_BYTES));

    a_r5_handover: assert property (@(posedge clk) disable iff (rst)
        adv && blk_end && nvalid && !wr_cur && !wr_next |=> cur == $past(nxt) && upd && !nvalid);

    a_r6_hold_on_overrun: assert property (@(posedge clk) disable iff (rst)
        adv && blk_end && !nvalid && !wr_cur |=> ovr && cur == $past(cur));

    a_r7_next_valid: assert property (@(posedge clk) disable iff (rst)
        wr_next |=> nvalid);

endmodule

// File: rtl/dmachan_engine.sv
module dmachan_engine
    import dmachan_pkg::*;
#(
    parameter int AW = 32,
    parameter int BW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    en,
    input  logic [AW-1:0] cur_tx,
    input  logic [AW-1:0] cur_rx,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_gnt,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_rvalid,
    output logic [31:0]   mem_wdata,
    output logic          mem_wvalid,
    output logic [15:0]   dev_tx_data,
    output logic          dev_tx_valid,
    input  logic          dev_tx_ready,
    input  logic [15:0]   dev_rx_data,
    input  logic          dev_rx_valid,
    output logic          dev_rx_ready,
    output logic [1:0]    adv
);

    localparam int IW = (BW > 1) ? $clog2(BW) : 1;

    eng_st_e       st;
    dir_e          dir;
    logic          last_rx;
    logic [IW-1:0] widx;
    logic          hsel;
    logic [31:0]   stage [2**IW];
    logic          last_w;
    logic          pick_rx;

    assign last_w  = (widx == IW'(BW - 1));
    assign pick_rx = en[1] && (!en[0] || !last_rx);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            dir     <= DIR_TX;
            last_rx <= 1'b0;
            widx    <= '0;
            hsel    <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (|en) begin
                    dir     <= pick_rx ? DIR_RX : DIR_TX;
                    last_rx <= pick_rx;
                    widx    <= '0;
                    hsel    <= 1'b0;
                    st      <= pick_rx ? ST_FILL : ST_REQ;
                end
                ST_FILL: if (dev_rx_valid) begin
                    hsel <= ~hsel;
                    if (hsel) begin
                        widx <= last_w ? '0 : widx + 1'b1;
                        if (last_w) st <= ST_REQ;
                    end
                end
                ST_REQ: if (mem_gnt) begin
                    widx <= '0;
                    st   <= (dir == DIR_RX) ? ST_MWR : ST_MRD;
                end
                ST_MRD: if (mem_rvalid) begin
                    widx <= last_w ? '0 : widx + 1'b1;
                    hsel <= 1'b0;
                    if (last_w) st <= ST_DRAIN;
                end
                ST_DRAIN: if (dev_tx_ready) begin
                    hsel <= ~hsel;
                    if (hsel) begin
                        widx <= widx + 1'b1;
                        if (last_w) st <= ST_DONE;
                    end
                end
                ST_MWR: begin
                    widx <= widx + 1'b1;
                    if (last_w) st <= ST_DONE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (st == ST_FILL && dev_rx_valid) begin
            if (hsel) stage[widx][31:16] <= dev_rx_data;
            else      stage[widx][15:0]  <= dev_rx_data;
        end
        if (st == ST_MRD && mem_rvalid) stage[widx] <= mem_rdata;
    end

    assign mem_req      = (st == ST_REQ);
    assign mem_we       = (dir == DIR_RX);
    assign mem_addr     = (dir == DIR_RX) ? cur_rx : cur_tx;
    assign mem_wvalid   = (st == ST_MWR);
    assign mem_wdata    = stage[widx];
    assign dev_tx_valid = (st == ST_DRAIN);
    assign dev_tx_data  = half_of(stage[widx], hsel);
    assign dev_rx_ready = (st == ST_FILL);
    assign adv          = (st != ST_DONE) ? 2'b00 : ((dir == DIR_RX) ? 2'b10 : 2'b01);

    a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    a_r12_tx_hold: assert property (@(posedge clk) disable iff (rst)
        dev_tx_valid && !dev_tx_ready |=> dev_tx_valid && $stable(dev_tx_data));

    a_r11_single_adv: assert property (@(posedge clk) disable iff (rst)
        $onehot0(adv));

    a_r3_no_write_while_req: assert property (@(posedge clk) disable iff (rst)
        !(mem_wvalid && mem_req));

endmodule

// File: rtl/dbl_dma_channel.sv
module dbl_dma_channel
    import dmachan_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BURST_WORDS = 4,
    parameter int BLK_LOG2    = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [2:0]        mem_len,
    input  logic              mem_gnt,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_rvalid,
    output logic [31:0]       mem_wdata,
    output logic              mem_wvalid,
    output logic [15:0]       dev_tx_data,
    output logic              dev_tx_valid,
    input  logic              dev_tx_ready,
    input  logic [15:0]       dev_rx_data,
    input  logic              dev_rx_valid,
    output logic              dev_rx_ready
);

    localparam int BURST_BYTES = 4 * BURST_WORDS;

    ctrl_t             ctrl;
    logic [ADDR_W-1:0] cur_a [2];
    logic [ADDR_W-1:0] nxt_a [2];
    logic [1:0]        nvalid, upd, ovr, stop, adv;
    logic              wr_stat;

    assign wr_stat = reg_wr && (reg_addr == RA_STAT);
    assign mem_len = 3'(BURST_WORDS);

    for (genvar d = 0; d < 2; d++) begin : g_dir
        localparam logic [2:0] A_CUR = (d == 0) ? RA_TXCUR : RA_RXCUR;
        localparam logic [2:0] A_NXT = (d == 0) ? RA_TXNXT : RA_RXNXT;
        dmachan_ptr_pair #(
            .AW(ADDR_W), .BURST_BYTES(BURST_BYTES), .BLK_LOG2(BLK_LOG2)
        ) u_pp (
            .clk     (clk),
            .rst     (rst),
            .wr_cur  (reg_wr && reg_addr == A_CUR),
            .wr_next (reg_wr && reg_addr == A_NXT),
            .wdata   (reg_wdata[ADDR_W-1:0]),
            .clr_upd (wr_stat && reg_wdata[d]),
            .clr_ovr (wr_stat && reg_wdata[2+d]),
            .adv     (adv[d]),
            .cur     (cur_a[d]),
            .nxt     (nxt_a[d]),
            .nvalid  (nvalid[d]),
            .upd     (upd[d]),
            .ovr     (ovr[d]),
            .stop_o  (stop[d])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else begin
            if (reg_wr && reg_addr == RA_CTRL) begin
                ctrl.ie <= reg_wdata[7:4];
                ctrl.en <= reg_wdata[1:0];
            end
            for (int d = 0; d < 2; d++) begin
                if (stop[d]) ctrl.en[d] <= 1'b0;
            end
        end
    end

    assign irq = |({ovr[1], ovr[0], upd[1], upd[0]} & ctrl.ie);

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL:  reg_rdata = {24'd0, ctrl.ie, 2'b00, ctrl.en};
            RA_STAT:  reg_rdata = {22'd0, nvalid, 4'd0, ovr[1], ovr[0], upd[1], upd[0]};
            RA_TXCUR: reg_rdata[ADDR_W-1:0] = cur_a[0];
            RA_TXNXT: reg_rdata[ADDR_W-1:0] = nxt_a[0];
            RA_RXCUR: reg_rdata[ADDR_W-1:0] = cur_a[1];
            RA_RXNXT: reg_rdata[ADDR_W-1:0] = nxt_a[1];
            default:  reg_rdata = '0;
        endcase
    end

    dmachan_engine #(.AW(ADDR_W), .BW(BURST_WORDS)) u_eng (
        .clk          (clk),
        .rst          (rst),
        .en           (ctrl.en),
        .cur_tx       (cur_a[0]),
        .cur_rx       (cur_a[1]),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_gnt      (mem_gnt),
        .mem_rdata    (mem_rdata),
        .mem_rvalid   (mem_rvalid),
        .mem_wdata    (mem_wdata),
        .mem_wvalid   (mem_wvalid),
        .dev_tx_data  (dev_tx_data),
        .dev_tx_valid (dev_tx_valid),
        .dev_tx_ready (dev_tx_ready),
        .dev_rx_data  (dev_rx_data),
        .dev_rx_valid (dev_rx_valid),
        .dev_rx_ready (dev_rx_ready),
        .adv          (adv)
    );

    a_r6_stop_disables: assert property (@(posedge clk) disable iff (rst)
        stop[0] |=> !ctrl.en[0]);

    a_r6_rx_stop_disables: assert property (@(posedge clk) disable iff (rst)
        stop[1] |=> !ctrl.en[1]);

    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (ctrl.ie == 4'd0) |-> !irq);

    a_r8_ovr_clear: assert property (@(posedge clk) disable iff (rst)
        wr_stat && reg_wdata[2] && !stop[0] |=> !ovr[0]);

endmodule

// File: tb/dbl_dma_channel_bench.sv
module dbl_dma_channel_bench;

    localparam int BW  = 4;
    localparam int BL  = 5;
    localparam int BLK = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        mem_req, mem_we, mem_wvalid, dev_tx_valid, dev_rx_ready;
    logic [31:0] mem_addr, mem_wdata;
    logic [2:0]  mem_len;
    logic        mem_gnt = 1'b0, mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [15:0] dev_tx_data;
    logic        dev_tx_ready = 1'b0, dev_rx_valid = 1'b0;
    logic [15:0] dev_rx_data = '0;

    always #2 clk = ~clk;

    dbl_dma_channel #(.ADDR_W(32), .BURST_WORDS(BW), .BLK_LOG2(BL)) u_dbl_dma_channel (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_len(mem_len), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .mem_rvalid(mem_rvalid), .mem_wdata(mem_wdata), .mem_wvalid(mem_wvalid),
        .dev_tx_data(dev_tx_data), .dev_tx_valid(dev_tx_valid), .dev_tx_ready(dev_tx_ready),
        .dev_rx_data(dev_rx_data), .dev_rx_valid(dev_rx_valid), .dev_rx_ready(dev_rx_ready)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    logic [31:0] mem [256];
    logic [15:0] tx_got [512];
    int          tx_n = 0, rx_i = 0;
    logic        g_dir [128];
    int          g_n = 0;
    bit          m_busy = 1'b0, m_rd = 1'b0;
    logic [31:0] m_addr = '0;
    int          m_cnt = 0;

    function automatic logic [15:0] src_half(int i);
        return 16'((i * 40503 + 7) ^ 23130);
    endfunction

    // memory model: grants, read data, write capture
    always @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] = $urandom;
            m_busy = 1'b0; mem_gnt = 1'b0; mem_rvalid = 1'b0;
        end else if (!m_busy) begin
            mem_rvalid = 1'b0;
            if (mem_req && !mem_gnt && ($urandom % 3 != 0)) begin
                mem_gnt = 1'b1; m_busy = 1'b1; m_rd = !mem_we;
                m_addr = mem_addr; m_cnt = 0;
                if (g_n < 128) g_dir[g_n] = mem_we;
                g_n++;
            end else begin
                mem_gnt = 1'b0;
            end
        end else begin
            mem_gnt = 1'b0;
            if (m_rd) begin
                if (m_cnt == BW) begin
                    mem_rvalid = 1'b0; m_busy = 1'b0;
                end else if ($urandom % 4 != 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = mem[8'(m_addr[9:2] + 8'(m_cnt))];
                    m_cnt++;
                end else begin
                    mem_rvalid = 1'b0;
                end
            end else if (mem_wvalid) begin
                mem[8'(m_addr[9:2] + 8'(m_cnt))] = mem_wdata;
                m_cnt++;
                if (m_cnt == BW) m_busy = 1'b0;
            end
        end
    end

    // device model: random ready on transmit, random valid on receive
    always @(negedge clk) begin
        if (!rst) begin
            dev_tx_ready = ($urandom % 3 != 0);
            if (dev_tx_valid && dev_tx_ready) begin
                if (tx_n < 512) tx_got[tx_n] = dev_tx_data;
                tx_n++;
            end
            dev_rx_valid = ($urandom % 3 != 0);
            dev_rx_data  = src_half(rx_i);
            if (dev_rx_valid && dev_rx_ready) rx_i++;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_stat(logic [31:0] mask, string req);
        logic [31:0] s;
        int t = 0;
        do begin rd(3'd1, s); t++; end while ((s & mask) != mask && t < 5000);
        if (t >= 5000) chk(req, s & mask, mask);
    endtask

    function automatic logic [15:0] exp_tx(int k, logic [31:0] b0, logic [31:0] b1, logic [31:0] b2);
        int off = (k / 2) * 4;
        int blk = off / BLK;
        logic [31:0] a = ((blk == 0) ? b0 : (blk == 1) ? b1 : b2) + 32'(off % BLK);
        return (k % 2 != 0) ? mem[a[9:2]][31:16] : mem[a[9:2]][15:0];
    endfunction

    function automatic int tx_bad(int base, int n, logic [31:0] b0, logic [31:0] b1, logic [31:0] b2);
        int e = 0;
        for (int k = 0; k < n; k++) if (tx_got[base + k] !== exp_tx(k, b0, b1, b2)) e++;
        return e;
    endfunction

    function automatic int rx_bad(int base, logic [31:0] r0, logic [31:0] r1);
        int e = 0;
        for (int w = 0; w < 2 * BLK / 4; w++) begin
            logic [31:0] a = ((w < BLK / 4) ? r0 : r1) + 32'((w % (BLK / 4)) * 4);
            if (mem[a[9:2]] !== {src_half(base + 2 * w + 1), src_half(base + 2 * w)}) e++;
        end
        return e;
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        int tb, rb, gb, sw;
        logic [31:0] t0, t1, r0, r1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(3'd0, v); chk("R1 ctrl", v, 32'h0);
        rd(3'd1, v); chk("R1 status", v, 32'h0);
        rd(3'd2, v); chk("R1 txcur", v, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 mem_req", {31'd0, mem_req}, 32'd0);

        // transmit two blocks then overrun (R2 R4 R5 R6 R9)
        tb = tx_n;
        wr(3'd2, 32'h40); wr(3'd3, 32'h100); wr(3'd0, 32'hF1);
        wait_stat(32'h4, "R6 tx overrun timeout");
        repeat (20) @(negedge clk);
        chk("R2 tx half count", 32'(tx_n - tb), 32'd32);
        chk("R2 tx data low-first", 32'(tx_bad(tb, 32, 32'h40, 32'h100, 32'h0)), 32'd0);
        rd(3'd1, v); chk("R5 R6 status", v, 32'h5);
        rd(3'd0, v); chk("R6 enable cleared", v, 32'hF0);
        rd(3'd2, v); chk("R4 R6 txcur held", v, 32'h110);
        chk("R9 irq on", {31'd0, irq}, 32'd1);
        chk("R6 no request", {31'd0, mem_req}, 32'd0);
        chk("R6 no more halves", 32'(tx_n - tb), 32'd32);

        // R8 write-one-to-clear, R9 masking
        wr(3'd1, 32'h0);  rd(3'd1, v); chk("R8 zero write keeps", v, 32'h5);
        wr(3'd1, 32'h4);  rd(3'd1, v); chk("R8 clear ovr", v, 32'h1);
        wr(3'd0, 32'h00); #1 chk("R9 masked", {31'd0, irq}, 32'd0);
        wr(3'd0, 32'h10); #1 chk("R9 tx upd enabled", {31'd0, irq}, 32'd1);
        wr(3'd1, 32'h1);  #1 chk("R9 cleared", {31'd0, irq}, 32'd0);

        // R7 queued pointer valid flag
        wr(3'd3, 32'h300); rd(3'd1, v); chk("R7 tx next valid", v, 32'h100);

        // reload in time, then disable (R5 R10)
        tb = tx_n;
        wr(3'd2, 32'h200); wr(3'd0, 32'h01);
        wait_stat(32'h1, "R5 first handover timeout");
        rd(3'd1, v); chk("R5 valid cleared", v & 32'h100, 32'h0);
        wr(3'd3, 32'h380); wr(3'd1, 32'h1);
        wait_stat(32'h1, "R5 second handover timeout");
        wr(3'd0, 32'h0);
        repeat (100) @(negedge clk);
        sw = tx_n - tb;
        chk("R10 whole bursts", 32'((sw == 32) || (sw == 40)), 32'd1);
        chk("R5 R10 data", 32'(tx_bad(tb, sw, 32'h200, 32'h300, 32'h380)), 32'd0);
        rd(3'd2, v); chk("R10 txcur", v, (sw == 32) ? 32'h380 : 32'h390);
        repeat (30) @(negedge clk);
        rd(3'd2, v2); chk("R10 txcur stable", v2, v);
        rd(3'd3, v); chk("R10 txnext kept", v, 32'h380);
        rd(3'd1, v); chk("R5 no overrun", v & 32'h4, 32'h0);
        chk("R10 idle", 32'(tx_n - tb), 32'(sw));

        // receive (R3)
        wr(3'd1, 32'hF); wr(3'd0, 32'h0);
        rb = rx_i;
        wr(3'd4, 32'hC0); wr(3'd5, 32'h180); wr(3'd0, 32'h82);
        wait_stat(32'h8, "R6 rx overrun timeout");
        repeat (10) @(negedge clk);
        chk("R3 rx half count", 32'(rx_i - rb), 32'd32);
        chk("R3 rx data", 32'(rx_bad(rb, 32'hC0, 32'h180)), 32'd0);
        rd(3'd1, v); chk("R5 R6 rx status", v, 32'hA);
        rd(3'd4, v); chk("R6 rxcur held", v, 32'h190);
        chk("R9 rx ovr irq", {31'd0, irq}, 32'd1);

        // random concurrent rounds (R11 R2 R3)
        for (int r = 0; r < 3; r++) begin
            wr(3'd1, 32'hF);
            t0 = 32'(($urandom % 8) * 32);
            t1 = 32'((((t0 / 32) + 1 + ($urandom % 7)) % 8) * 32);
            r0 = 32'h200 + 32'(($urandom % 8) * 32);
            r1 = 32'h200 + 32'((((r0 - 32'h200) / 32 + 1 + ($urandom % 7)) % 8) * 32);
            tb = tx_n; rb = rx_i; gb = g_n;
            wr(3'd2, t0); wr(3'd3, t1); wr(3'd4, r0); wr(3'd5, r1);
            wr(3'd0, 32'h03);
            wait_stat(32'hC, "R11 dual run timeout");
            repeat (10) @(negedge clk);
            chk("R2 dual tx data", 32'(tx_bad(tb, tx_n - tb, t0, t1, 32'h0) + ((tx_n - tb == 32) ? 0 : 1)), 32'd0);
            chk("R3 dual rx data", 32'(rx_bad(rb, r0, r1) + ((rx_i - rb == 32) ? 0 : 1)), 32'd0);
            sw = 0;
            for (int g = gb + 1; g < gb + 8; g++) if (g_dir[g] == g_dir[g - 1]) sw++;
            chk("R11 alternation", 32'(sw), 32'd0);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule